// File: doc/BRIEF.md
# Clock Time-Set Key Strober

This block sits between three raw push-buttons and the hour, minute and second counters of a digital clock. Each button is active-low. The block samples it only on a slow sampling enable, which is nominally 32 Hz. It accepts a new key level once that level has been seen on a set number of consecutive samples, two by default. This filters contact bounce and chatter without an analogue network.

For each button the block drives an increment strobe that is one system-clock cycle wide. When a debounced press is recognised, the block issues one strobe. While the key stays down, it issues one more strobe for every pulse of a separate 8 Hz repeat enable. A quick tap therefore steps its counter once, and a held key scrolls it. When a key is up, no strobe reaches its counter, so the counter keeps normal time. The three channels do not interact. Both enables come from the clock's own dividers as single-cycle pulses in the system clock domain.

Top module: `adj_key_strober`

## Requirements
- R1: Bit 0 of `key_n` and `inc_strobe` is the seconds key, bit 1 is the minutes key and bit 2 is the hours key. Each channel behaves independently of the others, including when several keys are down together.
- R2: The raw key level is captured only in cycles where `sample_en` is 1. A key change that is present only between sampling cycles has no effect.
- R3: A key becomes debounced-pressed at the clock edge that captures its second consecutive low sample. A single low sample between high samples gives no strobe.
- R4: A pressed key becomes released only at the edge that captures its second consecutive high sample. Repeat strobes continue after one high sample.
- R5: When a key becomes pressed at edge E, its strobe is 1 in the cycle after edge E+1.
- R6: If a key has been pressed for at least two edges and `repeat_en` is 1 in a cycle, its strobe is 1 in the cycle after that edge.
- R7: A `repeat_en` pulse in the cycle where the press is recognised, or in the cycle that produces the press strobe, adds no extra strobe. A tap with no repeat pulse in its pressed window gives exactly one strobe.
- R8: Each strobe is 1 for exactly one cycle per press or per repeat pulse.
- R9: While `rst_n` is 0 all strobes are 0. Reset clears the debounce state, so a key held through reset gives a fresh press strobe after two new low samples.
- R10: A released key produces no strobe, whatever `repeat_en` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Single-cycle pulse at the debounce sampling rate |
| repeat_en | input | 1 | Single-cycle pulse at the 8 Hz auto-repeat rate |
| key_n | input | NUM_KEYS | Raw active-low keys: bit 0 seconds, bit 1 minutes, bit 2 hours |
| inc_strobe | output | NUM_KEYS | One-cycle increment strobes, same bit order as `key_n` |

## Verification
A corrupted sample history shows up at the ports as a strobe that arrives one sampling period early or late, or that comes from a single bounce sample. The bench checks this against the exact edge it expects. A stuck pressed flag shows up at the first `repeat_en` pulse after release as a stray strobe. A wrong previous-level register shows up within two cycles of the press as a missing or doubled press strobe. The scoreboard ties every strobe to its channel and cycle, so a strobe on the wrong bit or in the wrong cycle counts as a failure.

// File: rtl/adjkey_pkg.sv
package adjkey_pkg;

  localparam int HIST_W_MAX = 8;

  typedef logic [HIST_W_MAX-1:0] hist_t;

  // shift a new pressed-level sample into the history, newest in bit 0
  function automatic hist_t hist_push(hist_t h, logic pressed_lvl);
    return {h[HIST_W_MAX-2:0], pressed_lvl};
  endfunction

  // true when the newest 'depth' samples all equal 'level'
  function automatic logic hist_all(hist_t h, int depth, logic level);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < HIST_W_MAX; b++) begin
      if (b < depth && h[b] != level) ok = 1'b0;
    end
    return ok;
  endfunction

  // strobe request: fresh press, or repeat tick on an established press
  function automatic logic strobe_next(logic rise, logic held, logic tick);
    return rise | (held & tick);
  endfunction

endpackage

// File: rtl/adjkey_debounce.sv
module adjkey_debounce
  import adjkey_pkg::*;
#(
  parameter int STABLE_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic key_n,
  output logic pressed
);

  localparam int DEPTH = (STABLE_SAMPLES > HIST_W_MAX) ? HIST_W_MAX :
                         (STABLE_SAMPLES < 1) ? 1 : STABLE_SAMPLES;

  hist_t hist_q;
  hist_t hist_nxt;
  logic  all_low;
  logic  all_high;

  assign hist_nxt = hist_push(hist_q, ~key_n);
  assign all_low  = hist_all(hist_nxt, DEPTH, 1'b1);
  assign all_high = hist_all(hist_nxt, DEPTH, 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      pressed <= 1'b0;
    end else if (sample_en) begin
      hist_q <= hist_nxt;
      if (all_low)       pressed <= 1'b1;
      else if (all_high) pressed <= 1'b0;
    end
  end

endmodule

// File: rtl/adjkey_repeat.sv
module adjkey_repeat
  import adjkey_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pressed,
  input  logic repeat_en,
  output logic press_rise,
  output logic strobe
);

  logic pressed_q;
  logic held;

  assign press_rise = pressed & ~pressed_q;
  assign held       = pressed & pressed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pressed_q <= 1'b0;
      strobe    <= 1'b0;
    end else begin
      pressed_q <= pressed;
      strobe    <= strobe_next(press_rise, held, repeat_en);
    end
  end

endmodule

// File: rtl/adj_key_strober.sv
module adj_key_strober #(
  parameter int NUM_KEYS       = 3,
  parameter int STABLE_SAMPLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                repeat_en,
  input  logic [NUM_KEYS-1:0] key_n,
  output logic [NUM_KEYS-1:0] inc_strobe
);

  // internal events, named for the bound checker
  logic [NUM_KEYS-1:0] key_pressed;
  logic [NUM_KEYS-1:0] press_rise;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    adjkey_debounce #(.STABLE_SAMPLES(STABLE_SAMPLES)) u_deb (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .key_n     (key_n[k]),
      .pressed   (key_pressed[k])
    );

    adjkey_repeat u_rep (
      .clk        (clk),
      .rst_n      (rst_n),
      .pressed    (key_pressed[k]),
      .repeat_en  (repeat_en),
      .press_rise (press_rise[k]),
      .strobe     (inc_strobe[k])
    );
  end

endmodule

// File: rtl/adj_key_strober_chk.sv
module adj_key_strober_chk #(
  parameter int NUM_KEYS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_en,
  input logic                repeat_en,
  input logic [NUM_KEYS-1:0] pressed,
  input logic [NUM_KEYS-1:0] rise,
  input logic [NUM_KEYS-1:0] inc
);

  // debounced state moves only on sampling cycles
  assert_sample_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(pressed));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (inc == '0);
    end
  end

  for (genvar i = 0; i < NUM_KEYS; i++) begin : g_ch
    assert_press_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pressed[i]) |=> inc[i]);

    assert_rise_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> inc[i]);

    assert_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pressed[i] && $past(pressed[i]) && repeat_en) |=> inc[i]);

    assert_released_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pressed[i] && !$past(pressed[i])) |=> !inc[i]);

    assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[i] && !repeat_en) |=> !inc[i]);
  end

endmodule

bind adj_key_strober adj_key_strober_chk #(.NUM_KEYS(NUM_KEYS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_en (sample_en),
  .repeat_en (repeat_en),
  .pressed   (key_pressed),
  .rise      (press_rise),
  .inc       (inc_strobe)
);

// File: tb/adj_key_strober_tb.sv
module adj_key_strober_tb;

  localparam int NK = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_en = 1'b0;
  logic          repeat_en = 1'b0;
  logic [NK-1:0] key_n = '1;
  logic [NK-1:0] inc_strobe;

  always #4 clk = ~clk;

  adj_key_strober #(.NUM_KEYS(NK), .STABLE_SAMPLES(2)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .repeat_en  (repeat_en),
    .key_n      (key_n),
    .inc_strobe (inc_strobe)
  );

  typedef struct { int ch; int cyc; } exp_t;
  exp_t q[$];

  int  tests = 0;
  int  fails = 0;
  int  cyc = 0;
  bit  done = 0;

  // spec model state per channel
  int lowrun[NK];
  int highrun[NK];
  bit mp[NK];
  bit mpq[NK];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic model_clear();
    for (int c = 0; c < NK; c++) begin
      lowrun[c] = 0; highrun[c] = 0; mp[c] = 0; mpq[c] = 0;
    end
    q.delete();
  endtask

  // driver: one cycle of stimulus, expected strobes pushed for the coming edge
  task automatic step(bit samp, bit rep, logic [NK-1:0] kn);
    @(negedge clk);
    sample_en = samp;
    repeat_en = rep;
    key_n     = kn;
    for (int c = 0; c < NK; c++) begin
      exp_t e;
      if ((mp[c] && !mpq[c]) || (mp[c] && mpq[c] && rep)) begin
        e.ch = c; e.cyc = cyc + 1;
        q.push_back(e);
      end
      mpq[c] = mp[c];
      if (samp) begin
        if (!kn[c]) begin lowrun[c]++; highrun[c] = 0; end
        else begin highrun[c]++; lowrun[c] = 0; end
        if (lowrun[c] >= 2) mp[c] = 1;
        if (highrun[c] >= 2) mp[c] = 0;
      end
    end
  endtask

  task automatic idle(int n, logic [NK-1:0] kn);
    for (int i = 0; i < n; i++) step(0, 0, kn);
  endtask

  task automatic drained(string req);
    idle(3, key_n);
    @(negedge clk);
    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected strobes missing (actual %0d pending, expected 0)", req, q.size(), q.size());
      q.delete();
    end
  endtask

  // monitor: compare produced strobes against the scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      tests++;
      if (inc_strobe !== '0) begin
        fails++;
        $display("FAIL R9: strobe during reset actual %b expected 000", inc_strobe);
      end
    end else if (!done) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
        tests++; fails++;
        $display("FAIL R5/R6: missing strobe ch %0d actual none expected at cycle %0d", q[0].ch, q[0].cyc);
        void'(q.pop_front());
      end
      for (int c = 0; c < NK; c++) begin
        if (inc_strobe[c] === 1'b1) begin
          tests++;
          if (q.size() > 0 && q[0].ch == c && q[0].cyc == cyc) begin
            void'(q.pop_front());
          end else begin
            fails++;
            $display("FAIL R1/R8/R10: unexpected strobe actual ch %0d cycle %0d expected %s", c, cyc,
                     (q.size() > 0) ? $sformatf("ch %0d cycle %0d", q[0].ch, q[0].cyc) : "none");
          end
        end else if (inc_strobe[c] !== 1'b0) begin
          tests++; fails++;
          $display("FAIL R8: strobe ch %0d actual %b expected 0/1", c, inc_strobe[c]);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_clear();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2: key low for a long time with no sampling pulse
    idle(20, 3'b110);
    step(1, 0, 3'b111); idle(2, 3'b111);
    step(1, 0, 3'b111); idle(2, 3'b111);
    drained("R2");

    // R3: bounce, single low samples between highs
    step(1, 0, 3'b110); idle(2, 3'b110);
    step(1, 0, 3'b111); idle(2, 3'b111);
    step(1, 1, 3'b110); idle(2, 3'b110);
    step(1, 0, 3'b111); step(1, 1, 3'b111);
    drained("R3");

    // R5, R7: tap on seconds key, no repeat pulse while pressed
    step(1, 0, 3'b110); idle(3, 3'b110);
    step(1, 0, 3'b110); idle(5, 3'b110);
    step(1, 0, 3'b111); idle(2, 3'b111);
    step(1, 0, 3'b111); idle(5, 3'b111);
    drained("R5");

    // R6, R4, R10: hold minutes key, repeat, one-sample release, full release
    step(1, 0, 3'b101); idle(2, 3'b101);
    step(1, 0, 3'b101); idle(4, 3'b101);
    for (int r = 0; r < 4; r++) begin
      step(0, 1, 3'b101); idle(5, 3'b101);
    end
    step(1, 0, 3'b111); idle(2, 3'b111);
    step(0, 1, 3'b111); idle(3, 3'b111);
    step(1, 0, 3'b111); idle(3, 3'b111);
    for (int r = 0; r < 3; r++) begin
      step(0, 1, 3'b111); idle(4, 3'b111);
    end
    drained("R6");

    // R7: repeat pulse on the press edge and on the rise cycle
    step(1, 0, 3'b011); idle(2, 3'b011);
    step(1, 1, 3'b011);
    step(0, 1, 3'b011);
    idle(4, 3'b011);
    step(0, 1, 3'b011); idle(3, 3'b011);
    step(1, 0, 3'b111); step(1, 0, 3'b111);
    drained("R7");

    // R1: hours and seconds together, minutes idle
    step(1, 0, 3'b010); idle(2, 3'b010);
    step(1, 0, 3'b010); idle(3, 3'b010);
    step(0, 1, 3'b010); idle(3, 3'b010);
    step(1, 0, 3'b011); idle(1, 3'b011);
    step(1, 0, 3'b011); idle(2, 3'b011);
    step(0, 1, 3'b011); idle(3, 3'b011);
    step(1, 0, 3'b111); step(1, 0, 3'b111);
    step(0, 1, 3'b111);
    drained("R1");

    // R9: reset while a key is held, then fresh press
    step(1, 0, 3'b110); step(1, 0, 3'b110); idle(4, 3'b110);
    @(negedge clk) rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3, 3'b110);
    step(1, 1, 3'b110); idle(2, 3'b110);
    step(1, 0, 3'b110); idle(4, 3'b110);
    step(1, 0, 3'b111); step(1, 0, 3'b111);
    drained("R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule